// File: doc/BRIEF.md
# Bus master cycle generator

This block gives a transfer engine direct use of a CPU-style parallel bus. When the engine raises its cycle request, the block asks the bus owner for the bus and waits for the grant. It then raises a master flag. The surrounding logic uses that flag to enable its address and strobe tri-state drivers.

For each access it runs a fixed three-phase template:

- Phase 1 presents the address.
- Phase 2 asserts the read or write strobe together with the memory or I/O strobe. The phase repeats while the wait input is active.
- Phase 3 removes the strobes and pulses a termination signal back to the engine.

Memory and I/O accesses share this template and differ only in which request strobe is used. A data-output enable marks the clocks in which write data may be driven. The bus is handed back once the engine stops asking. Register decoding and transfer sequencing are done elsewhere.

Top module: `bus_cycle_master`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) leaves the block released, with `busReq`, `master`, `dataOe`, all four strobes and `term` low. This also applies when reset is asserted in the middle of an access.
- R2: When `cycReq` is high in the released state, `busReq` goes high after one clock. No strobe and no `master` appear until `busAck` has been seen high. `busAck` has no effect while no request is pending.
- R3: `master` goes high on the clock after `busAck` is sampled high with `busReq` asserted. `master` is never high while `busReq` is low.
- R4: An access with no wait lasts three clocks. In the first clock no strobe is active. In the second clock exactly one of `rdStb`/`wrStb` and exactly one of `memStb`/`ioStb` are high. In the third clock the strobes are low and `term` is high for that one clock only.
- R5: `cycIo` = 1 at the start of an access selects `ioStb`, and `cycIo` = 0 selects `memStb`. The two are never high together.
- R6: `cycWrite` = 1 selects `wrStb`, and `cycWrite` = 0 selects `rdStb`. `dataOe` is high in all three phases of a write, never during a read, and never while `master` is low.
- R7: Each rising edge in the strobe phase that samples `busWait` high extends that phase by one clock. The strobes stay high throughout.
- R8: If `cycReq` is still high in the termination phase, the next access starts its address phase on the following clock without releasing the bus. Back-to-back accesses therefore take three clocks each.
- R9: After an access, if `cycReq` is low, the block holds the bus for one idle clock. If `cycReq` is still low at the end of that clock, `busReq` and `master` both fall on the same edge.
- R10: Address, write data, direction and space are captured on the edge that enters the address phase. `addrOut` and `dataOut` stay at the captured values until the termination phase ends, whatever the inputs do.
- R11: If `cycReq` falls while the block is still waiting for the grant, `busReq` falls one clock later and no access is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cycReq | input | 1 | Engine asks for (another) bus access |
| cycWrite | input | 1 | Access is a write (1) or a read (0) |
| cycIo | input | 1 | Access targets I/O space (1) or memory (0) |
| cycAddr | input | ADDR_W | Address of the requested access |
| cycData | input | DATA_W | Data for a write access |
| busAck | input | 1 | Bus grant from the current owner, active high |
| busWait | input | 1 | Bus wait request, active high |
| busReq | output | 1 | Bus request to the current owner, active high |
| master | output | 1 | Bus is owned; enables address and strobe drivers |
| addrOut | output | ADDR_W | Captured address for the bus |
| dataOut | output | DATA_W | Captured write data for the bus |
| dataOe | output | 1 | Data drivers may be enabled (write, bus owned) |
| rdStb | output | 1 | Read strobe, active high |
| wrStb | output | 1 | Write strobe, active high |
| memStb | output | 1 | Memory request strobe, active high |
| ioStb | output | 1 | I/O request strobe, active high |
| term | output | 1 | One-clock pulse when an access completes |

## Verification
Every output is decoded straight from the phase register and the captured access fields, so a wrong phase is visible at the ports in the same clock. A skipped or repeated phase shows up as a strobe window of the wrong length, or as a `term` pulse that arrives early, late or twice. A missing return to the released state shows up as `busReq` or `master` still high two clocks after the final `term`. A bad capture shows up as `addrOut` or `dataOut` following the engine inputs in the middle of an access.

// File: rtl/bus_cycle_pkg.sv
package bus_cycle_pkg;

  // Bus ownership and access phases
  typedef enum logic [2:0] {
    PH_RELEASED  = 3'd0,
    PH_ARBITRATE = 3'd1,
    PH_OWNED     = 3'd2,
    PH_ADDR      = 3'd3,
    PH_STROBE    = 3'd4,
    PH_TERM      = 3'd5
  } phase_e;

  // Control-to-datapath strobe bundle
  typedef struct packed {
    logic capture;   // load access fields on this edge
    logic inCycle;   // any of the three access phases
    logic strobeOn;  // request/direction strobes active
    logic drive;     // bus is owned
  } ctrlStb_t;

endpackage

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
  import bus_cycle_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cycReq,
  input  logic     busAck,
  input  logic     busWait,
  output logic     busReq,
  output logic     master,
  output logic     term,
  output ctrlStb_t ctrl
);

  phase_e phase, nextPhase;

  always_comb begin
    nextPhase = phase;
    unique case (phase)
      PH_RELEASED:  if (cycReq) nextPhase = PH_ARBITRATE;
      PH_ARBITRATE: begin
        if (!cycReq)     nextPhase = PH_RELEASED;
        else if (busAck) nextPhase = PH_ADDR;
      end
      PH_OWNED: begin
        if (!busAck || !cycReq) nextPhase = PH_RELEASED;
        else                    nextPhase = PH_ADDR;
      end
      PH_ADDR:   nextPhase = PH_STROBE;
      PH_STROBE: if (!busWait) nextPhase = PH_TERM;
      PH_TERM:   nextPhase = cycReq ? PH_ADDR : PH_OWNED;
      default:   nextPhase = PH_RELEASED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_RELEASED;
    else     phase <= nextPhase;
  end

  logic inCycle;
  assign inCycle = (phase == PH_ADDR) || (phase == PH_STROBE) || (phase == PH_TERM);

  assign busReq = (phase != PH_RELEASED);
  assign master = inCycle || (phase == PH_OWNED);
  assign term   = (phase == PH_TERM);

  assign ctrl.capture  = (nextPhase == PH_ADDR);
  assign ctrl.inCycle  = inCycle;
  assign ctrl.strobeOn = (phase == PH_STROBE);
  assign ctrl.drive    = master;

endmodule

// File: rtl/bus_cycle_dp.sv
module bus_cycle_dp
  import bus_cycle_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStb_t          ctrl,
  input  logic              cycWrite,
  input  logic              cycIo,
  input  logic [ADDR_W-1:0] cycAddr,
  input  logic [DATA_W-1:0] cycData,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              rdStb,
  output logic              wrStb,
  output logic              memStb,
  output logic              ioStb
);

  localparam logic [ADDR_W-1:0] ADDR_CLR = '0;
  localparam logic [DATA_W-1:0] DATA_CLR = '0;

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;
  logic              writeReg;
  logic              ioReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrReg  <= ADDR_CLR;
      dataReg  <= DATA_CLR;
      writeReg <= 1'b0;
      ioReg    <= 1'b0;
    end else if (ctrl.capture) begin
      addrReg  <= cycAddr;
      dataReg  <= cycData;
      writeReg <= cycWrite;
      ioReg    <= cycIo;
    end
  end

  assign addrOut = addrReg;
  assign dataOut = dataReg;
  assign dataOe  = ctrl.drive && ctrl.inCycle && writeReg;
  assign rdStb   = ctrl.strobeOn && !writeReg;
  assign wrStb   = ctrl.strobeOn &&  writeReg;
  assign memStb  = ctrl.strobeOn && !ioReg;
  assign ioStb   = ctrl.strobeOn &&  ioReg;

endmodule

// File: rtl/bus_cycle_master.sv
module bus_cycle_master
  import bus_cycle_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cycReq,
  input  logic              cycWrite,
  input  logic              cycIo,
  input  logic [ADDR_W-1:0] cycAddr,
  input  logic [DATA_W-1:0] cycData,
  input  logic              busAck,
  input  logic              busWait,
  output logic              busReq,
  output logic              master,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              rdStb,
  output logic              wrStb,
  output logic              memStb,
  output logic              ioStb,
  output logic              term
);

  ctrlStb_t ctrl;

  bus_cycle_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .cycReq  (cycReq),
    .busAck  (busAck),
    .busWait (busWait),
    .busReq  (busReq),
    .master  (master),
    .term    (term),
    .ctrl    (ctrl)
  );

  bus_cycle_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .cycWrite (cycWrite),
    .cycIo    (cycIo),
    .cycAddr  (cycAddr),
    .cycData  (cycData),
    .addrOut  (addrOut),
    .dataOut  (dataOut),
    .dataOe   (dataOe),
    .rdStb    (rdStb),
    .wrStb    (wrStb),
    .memStb   (memStb),
    .ioStb    (ioStb)
  );

endmodule

// File: rtl/bus_cycle_master_chk.sv
module bus_cycle_master_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              busAck,
  input logic              busWait,
  input logic              busReq,
  input logic              master,
  input logic [ADDR_W-1:0] addrOut,
  input logic              dataOe,
  input logic              rdStb,
  input logic              wrStb,
  input logic              memStb,
  input logic              ioStb,
  input logic              term
);

  logic spaceStb, dirStb;
  assign spaceStb = memStb || ioStb;
  assign dirStb   = rdStb || wrStb;

  AST_MASTER_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    master |-> busReq);  // R3
  AST_MASTER_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    $rose(master) |-> $past(busAck));  // R3
  AST_SPACE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({memStb, ioStb}));  // R5
  AST_DIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rdStb, wrStb}));  // R6
  AST_STROBE_PAIRED: assert property (@(posedge clk) disable iff (rst)
    dirStb == spaceStb);  // R4
  AST_STROBE_OWNED: assert property (@(posedge clk) disable iff (rst)
    spaceStb |-> master);  // R2
  AST_DATA_OWNED: assert property (@(posedge clk) disable iff (rst)
    dataOe |-> master);  // R6
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
    rdStb |-> !dataOe);  // R6
  AST_TERM_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    term |-> ($past(spaceStb) && !spaceStb));  // R4
  AST_TERM_SINGLE: assert property (@(posedge clk) disable iff (rst)
    term |=> !term);  // R4
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (spaceStb && busWait) |=> spaceStb);  // R7
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (spaceStb || term) |-> $stable(addrOut));  // R10
  AST_RELEASE_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    $fell(master) |-> $fell(busReq));  // R9

endmodule

bind bus_cycle_master bus_cycle_master_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .busAck  (busAck),
  .busWait (busWait),
  .busReq  (busReq),
  .master  (master),
  .addrOut (addrOut),
  .dataOe  (dataOe),
  .rdStb   (rdStb),
  .wrStb   (wrStb),
  .memStb  (memStb),
  .ioStb   (ioStb),
  .term    (term)
);

// File: tb/bus_cycle_master_tb.sv
module bus_cycle_master_tb;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int NVEC   = 6;

  // {write, io, addr, data, waits}
  localparam logic [28:0] VECS [NVEC] = '{
    {1'b0, 1'b0, 16'h1234, 8'h00, 3'd0},
    {1'b1, 1'b0, 16'h8001, 8'hA5, 3'd0},
    {1'b0, 1'b1, 16'h0098, 8'h00, 3'd2},
    {1'b1, 1'b1, 16'h00FE, 8'h3C, 3'd1},
    {1'b0, 1'b0, 16'hFFFF, 8'h00, 3'd4},
    {1'b1, 1'b0, 16'h0000, 8'hFF, 3'd3}
  };

  logic clk = 1'b0;
  logic rst, cycReq, cycWrite, cycIo, busAck, busWait;
  logic [ADDR_W-1:0] cycAddr;
  logic [DATA_W-1:0] cycData;
  logic busReq, master, dataOe, rdStb, wrStb, memStb, ioStb, term;
  logic [ADDR_W-1:0] addrOut;
  logic [DATA_W-1:0] dataOut;

  int nRun  = 0;
  int nFail = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  bus_cycle_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst), .cycReq(cycReq), .cycWrite(cycWrite), .cycIo(cycIo),
    .cycAddr(cycAddr), .cycData(cycData), .busAck(busAck), .busWait(busWait),
    .busReq(busReq), .master(master), .addrOut(addrOut), .dataOut(dataOut),
    .dataOe(dataOe), .rdStb(rdStb), .wrStb(wrStb), .memStb(memStb),
    .ioStb(ioStb), .term(term)
  );

  function automatic logic [3:0] stbs();
    return {rdStb, wrStb, memStb, ioStb};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic runAccess(input logic w, input logic io, input logic [15:0] a,
                           input logic [7:0] d, input int waits);
    logic [3:0] expStb;
    expStb = {!w, w, !io, io};
    cycReq = 1; cycWrite = w; cycIo = io; cycAddr = a; cycData = d; busAck = 0;
    @(negedge clk);  // arbitration
    check(busReq && !master, "R2", {busReq, master}, 2'b10);
    @(negedge clk);
    check(busReq && !master && stbs() == 0, "R2", {busReq, master, stbs()}, 6'b100000);
    busAck = 1;
    @(negedge clk);  // address phase
    check(master, "R3", master, 1);
    check(stbs() == 0 && !term, "R4", {stbs(), term}, 0);
    check(addrOut == a, "R10", addrOut, a);
    check(dataOe == w, "R6", dataOe, w);
    cycReq = 0; cycAddr = ~a; cycData = ~d; cycWrite = ~w; cycIo = ~io;
    busWait = (waits != 0);
    @(negedge clk);  // strobe phase
    check(stbs() == expStb, "R5", stbs(), expStb);
    check(dataOe == w, "R6", dataOe, w);
    if (w) check(dataOut == d, "R10", dataOut, d);
    for (int k = 0; k < waits; k++) begin
      @(negedge clk);
      check(stbs() == expStb && !term, "R7", {stbs(), term}, {expStb, 1'b0});
      busWait = (k + 1 < waits);
    end
    @(negedge clk);  // termination phase
    check(term && stbs() == 0, "R4", {term, stbs()}, 5'b10000);
    check(addrOut == a, "R10", addrOut, a);
    @(negedge clk);  // owned idle
    check(!term && master && busReq, "R9", {term, master, busReq}, 3'b011);
    @(negedge clk);
    check(!master && !busReq, "R9", {master, busReq}, 0);
    busAck = 0; busWait = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nFail++; nRun++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    rst = 1; cycReq = 0; cycWrite = 0; cycIo = 0; busAck = 0; busWait = 0;
    cycAddr = '0; cycData = '0;
    repeat (2) @(negedge clk);
    check({busReq, master, dataOe, stbs(), term} == 0, "R1",
          {busReq, master, dataOe, stbs(), term}, 0);
    rst = 0;
    busAck = 1;  // grant with no request pending: no effect
    @(negedge clk);
    check(!busReq && !master, "R2", {busReq, master}, 0);
    busAck = 0;

    // Table of accesses
    for (int i = 0; i < NVEC; i++)
      runAccess(VECS[i][28], VECS[i][27], VECS[i][26:11], VECS[i][10:3],
                int'(VECS[i][2:0]));

    // R8: back-to-back accesses, three clocks each
    cycReq = 1; cycWrite = 0; cycIo = 0; cycAddr = 16'h4000; busAck = 1;
    @(negedge clk);
    @(negedge clk);  // address phase 1
    check(master && addrOut == 16'h4000, "R8", addrOut, 16'h4000);
    @(negedge clk);  // strobe 1
    cycAddr = 16'h4001; cycWrite = 1; cycData = 8'h77;
    @(negedge clk);  // term 1
    check(term, "R8", term, 1);
    @(negedge clk);  // address phase 2
    check(!term && master && stbs() == 0 && addrOut == 16'h4001, "R8",
          {term, master, addrOut}, {2'b01, 16'h4001});
    cycReq = 0;
    @(negedge clk);  // strobe 2
    check(stbs() == 4'b0110 && dataOe, "R8", stbs(), 4'b0110);
    @(negedge clk);  // term 2
    check(term, "R8", term, 1);
    @(negedge clk);
    @(negedge clk);
    check(!busReq && !master, "R9", {busReq, master}, 0);
    busAck = 0;

    // R11: request withdrawn before the grant
    cycReq = 1;
    @(negedge clk);
    check(busReq, "R11", busReq, 1);
    cycReq = 0;
    @(negedge clk);
    check(!busReq && !master && stbs() == 0, "R11", {busReq, master}, 0);

    // R1: reset in the middle of an access
    cycReq = 1; cycWrite = 1; cycIo = 1; busAck = 1; busWait = 1;
    repeat (4) @(negedge clk);  // arbitration, address, strobe, strobe (held)
    check(ioStb && wrStb, "R7", {ioStb, wrStb}, 2'b11);
    rst = 1;
    @(negedge clk);
    check({busReq, master, dataOe, stbs(), term} == 0, "R1",
          {busReq, master, dataOe, stbs(), term}, 0);
    rst = 0; cycReq = 0; busAck = 0; busWait = 0;
    @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule